// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits between the pins of a serial-memory slave and its shifter. It lets the bus master pause a transfer in the middle of a byte and later carry on from the same bit. Chip-select, the hold request and the serial clock are all sampled by a faster system clock. Each passes through a synchroniser, and the block looks for edges on the synchronised copies.

A hold request only takes effect while the serial clock is low. When the request edge arrives during a clock-high phase, the block records it as pending and applies it at the next low sample. A later opposite edge cancels a pending transition. While paused, the block suppresses the shift enable and drops the data-out output enable. Releasing chip-select raises a one-cycle reset pulse for the slave's command logic and clears all hold state.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While chip-select (`cs_n`) is high, falling or rising edges of `hold_n` have no effect. `in_hold` stays 0, and after reselection with `hold_n` high the block is not paused.
- R2: A falling edge of `hold_n` that is seen while the synchronised clock is low, with the slave selected, sets `in_hold` to 1.
- R3: A falling edge of `hold_n` that is seen while the clock is high does not set `in_hold`. `in_hold` becomes 1 at the first low clock sample after it.
- R4: A rising edge of `hold_n` clears `in_hold` when the clock is low. If the clock is high, the clear is postponed to the next low clock sample.
- R5: `so_oe` is 1 exactly when the slave is selected and not paused. It has a single falling and a single rising transition across one hold episode.
- R6: `shift_en` pulses for one cycle on each rising serial-clock edge while the slave is selected and not paused. Clock edges during a pause produce no pulse, so the bit count continues across a mid-byte hold.
- R7: A rising edge of `cs_n` gives a one-cycle `slave_rst` pulse and clears the pause, even when `hold_n` is still low.
- R8: A pending entry is cancelled if `hold_n` rises again before any low clock sample. The pause is then never entered.
- R9: After reset all outputs are 0. An output reacts to a pin change on the third rising system-clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select pin, active low |
| hold_n | input | 1 | Hold request pin, active low |
| sck | input | 1 | Serial clock pin |
| shift_en | output | 1 | One-cycle enable to the slave's bit shifter |
| so_oe | output | 1 | Output enable for the serial data-out driver |
| in_hold | output | 1 | High while the transfer is paused |
| slave_rst | output | 1 | One-cycle reset for the slave's command logic |

## Verification
The deferred paths are the hardest cases to reach from the pins. In these, a hold edge must arrive inside a clock-high phase and be held pending across several system cycles. In the cancel case, the opposite edge must also land before the clock falls. The stimulus stretches the serial-clock high phase to eight system cycles and places the hold edges at fixed offsets inside it. A behavioural model, which tracks the last requested hold level and applies it at each low clock sample, is compared against every output on every cycle.

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic hold_n,
  input  logic sck,
  output logic shift_en,
  output logic so_oe,
  output logic in_hold,
  output logic slave_rst
);

  logic [SYNC_STAGES-1:0] cs_sy, hd_sy, ck_sy;
  logic cs_d, hd_d, ck_d;
  logic pend_in, pend_out;
  logic hold_nx, pin_nx, pout_nx;

  wire cs_s = cs_sy[SYNC_STAGES-1];
  wire hd_s = hd_sy[SYNC_STAGES-1];
  wire ck_s = ck_sy[SYNC_STAGES-1];

  wire cs_rise = cs_s & ~cs_d;
  wire hd_fall = ~hd_s & hd_d;
  wire hd_rise = hd_s & ~hd_d;
  wire ck_rise = ck_s & ~ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      hd_sy <= '1;
      ck_sy <= '0;
      cs_d  <= 1'b1;
      hd_d  <= 1'b1;
      ck_d  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      hd_sy <= {hd_sy[SYNC_STAGES-2:0], hold_n};
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], sck};
      cs_d  <= cs_s;
      hd_d  <= hd_s;
      ck_d  <= ck_s;
    end
  end

  always_comb begin
    hold_nx = in_hold;
    pin_nx  = pend_in;
    pout_nx = pend_out;
    if (cs_s) begin
      hold_nx = 1'b0;
      pin_nx  = 1'b0;
      pout_nx = 1'b0;
    end else if (!in_hold) begin
      pout_nx = 1'b0;
      if (hd_fall) begin
        if (ck_s) pin_nx = 1'b1;
        else begin
          hold_nx = 1'b1;
          pin_nx  = 1'b0;
        end
      end else if (hd_rise) begin
        pin_nx = 1'b0;
      end else if (pend_in && !ck_s) begin
        hold_nx = 1'b1;
        pin_nx  = 1'b0;
      end
    end else begin
      pin_nx = 1'b0;
      if (hd_rise) begin
        if (ck_s) pout_nx = 1'b1;
        else begin
          hold_nx = 1'b0;
          pout_nx = 1'b0;
        end
      end else if (hd_fall) begin
        pout_nx = 1'b0;
      end else if (pend_out && !ck_s) begin
        hold_nx = 1'b0;
        pout_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hold   <= 1'b0;
      pend_in   <= 1'b0;
      pend_out  <= 1'b0;
      so_oe     <= 1'b0;
      shift_en  <= 1'b0;
      slave_rst <= 1'b0;
    end else begin
      in_hold   <= hold_nx;
      pend_in   <= pin_nx;
      pend_out  <= pout_nx;
      so_oe     <= ~cs_s & ~hold_nx;
      shift_en  <= ~cs_s & ~hold_nx & ck_rise;
      slave_rst <= cs_rise;
    end
  end

  AST_ENTRY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hold) |-> !$past(cs_s)); // R1
  AST_ENTRY_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hold) |-> !$past(ck_s)); // R3
  AST_EXIT_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_hold) && !$past(cs_s)) |-> !$past(ck_s)); // R4
  AST_HOLD_TRISTATES_SO: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !so_oe); // R5
  AST_HOLD_FREEZES_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !shift_en); // R6
  AST_RESET_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rst |=> !slave_rst); // R7
  AST_RESET_CLEARS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slave_rst |-> !in_hold); // R7

endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, hold_n = 1'b1, sck = 1'b0;
  logic shift_en, so_oe, in_hold, slave_rst;

  spi_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .sck(sck),
    .shift_en(shift_en), .so_oe(so_oe), .in_hold(in_hold), .slave_rst(slave_rst)
  );

  int total = 0, bad = 0;
  int bits = 0, oe_edges = 0, rst_pulses = 0;
  logic oe_last = 1'b0;

  bit q_cs[$] = '{1, 1, 1};
  bit q_hd[$] = '{1, 1, 1};
  bit q_ck[$] = '{0, 0, 0};
  bit m_want = 0, m_hold = 0, m_oe = 0, m_sh = 0, m_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cs = '{1, 1, 1}; q_hd = '{1, 1, 1}; q_ck = '{0, 0, 0};
      m_want = 0; m_hold = 0; m_oe = 0; m_sh = 0; m_rst = 0;
    end else begin
      bit sel;
      sel = !q_cs[1];
      m_rst = q_cs[1] && !q_cs[0];
      if (!sel) begin
        m_want = 0;
        m_hold = 0;
      end else begin
        if (q_hd[0] && !q_hd[1]) m_want = 1;
        if (!q_hd[0] && q_hd[1]) m_want = 0;
        if (!q_ck[1]) m_hold = m_want;
      end
      m_oe = sel && !m_hold;
      m_sh = sel && !m_hold && q_ck[1] && !q_ck[0];
      void'(q_cs.pop_front()); q_cs.push_back(cs_n);
      void'(q_hd.pop_front()); q_hd.push_back(hold_n);
      void'(q_ck.pop_front()); q_ck.push_back(sck);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5", "so_oe vs model", so_oe, m_oe);
      check("R2", "in_hold vs model", in_hold, m_hold);
      check("R6", "shift_en vs model", shift_en, m_sh);
      check("R7", "slave_rst vs model", slave_rst, m_rst);
      if (shift_en) bits++;
      if (slave_rst) rst_pulses++;
      if (so_oe != oe_last) oe_edges++;
      oe_last = so_oe;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse(int hi, int lo);
    sck = 1'b1; wait_n(hi);
    sck = 1'b0; wait_n(lo);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    wait_n(3);
    check("R9", "reset so_oe", so_oe, 0);
    check("R9", "reset in_hold", in_hold, 0);
    check("R9", "reset shift_en", shift_en, 0);
    check("R9", "reset slave_rst", slave_rst, 0);
    rst_n = 1'b1;
    wait_n(4);

    cs_n = 1'b0;
    wait_n(2);
    check("R9", "so_oe before third edge", so_oe, 0);
    wait_n(1);
    check("R9", "so_oe on third edge", so_oe, 1);
    wait_n(3);

    bits = 0; oe_edges = 0;
    repeat (3) sck_pulse(4, 4);
    hold_n = 1'b0; wait_n(6);
    check("R2", "entry on low clock", in_hold, 1);
    check("R5", "so_oe off in hold", so_oe, 0);
    repeat (3) sck_pulse(4, 4);
    check("R6", "no shift in hold", bits, 3);
    hold_n = 1'b1; wait_n(6);
    check("R4", "exit on low clock", in_hold, 0);
    repeat (5) sck_pulse(4, 4);
    wait_n(4);
    check("R6", "bit count kept across hold", bits, 8);
    check("R5", "so_oe edges in one hold", oe_edges, 2);

    sck = 1'b1; wait_n(1);
    hold_n = 1'b0; wait_n(6);
    check("R3", "entry deferred while clock high", in_hold, 0);
    sck = 1'b0; wait_n(6);
    check("R3", "entry at next low clock", in_hold, 1);
    sck = 1'b1; wait_n(1);
    hold_n = 1'b1; wait_n(6);
    check("R4", "exit deferred while clock high", in_hold, 1);
    sck = 1'b0; wait_n(6);
    check("R4", "exit at next low clock", in_hold, 0);

    sck = 1'b1; wait_n(1);
    hold_n = 1'b0; wait_n(3);
    hold_n = 1'b1; wait_n(4);
    sck = 1'b0; wait_n(6);
    check("R8", "cancelled entry", in_hold, 0);
    check("R8", "so_oe after cancel", so_oe, 1);

    hold_n = 1'b0; wait_n(6);
    check("R7", "paused before deselect", in_hold, 1);
    rst_pulses = 0;
    cs_n = 1'b1; wait_n(8);
    check("R7", "single reset pulse", rst_pulses, 1);
    check("R7", "hold cleared by deselect", in_hold, 0);
    hold_n = 1'b1; wait_n(4);

    hold_n = 1'b0; wait_n(6);
    check("R1", "no hold while deselected", in_hold, 0);
    check("R1", "so_oe off while deselected", so_oe, 0);
    hold_n = 1'b1; wait_n(6);
    cs_n = 1'b0; wait_n(6);
    check("R1", "not paused after reselect", in_hold, 0);
    check("R1", "so_oe on after reselect", so_oe, 1);
    bits = 0;
    repeat (2) sck_pulse(4, 4);
    wait_n(4);
    check("R6", "shifting after reselect", bits, 2);

    finish_run();
  end
endmodule